// File: doc/BRIEF.md
# Audio Output Byte FIFO with Serial and Parallel Drain

This block buffers audio elementary-stream bytes and delivers them to an audio decoder. Bytes arrive on a write port at the system byte rate and are stored in a byte-wide FIFO of several kilobytes. On the read side, a programmable divider sets the output pace. In serial mode each pace pulse presents one bit, most significant bit first, and a new byte is taken from the FIFO only after all eight bits of the current one have been shown. In combined mode each pace pulse presents a whole byte on a parallel bus, and the interval between pulses comes from a separate ratio setting.

A valid output marks the cycles that carry real stream data. When the FIFO runs dry in serial mode, valid drops to 0. In combined mode an empty FIFO leaves both the byte and valid unchanged. A download select lets a host controller write bytes straight into the same FIFO, for example to load a short tone, in place of the demultiplexer. Writes that arrive while the FIFO is full are discarded and raise a sticky overflow flag. The host clears that flag with a one-cycle pulse. Everything runs on one clock.

Top module: `aud_out_fifo`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` and `ovf_flag` are 0 and the FIFO is empty.
- R2: `pace` pulses for one cycle every P+1 clocks. P is `rate_div` when `mode_comb`=0 and `byte_ratio` when `mode_comb`=1.
- R3: When `mode_comb`=0, each byte leaves on `ser_bit` over eight consecutive pace pulses, bit 7 first and bit 0 last. The next byte is popped only at the pulse after bit 0.
- R4: When `mode_comb`=0 and a byte is needed but the FIFO is empty, `out_valid` is 0 from that pulse until a later pulse loads a byte.
- R5: When `mode_comb`=1, each pace pulse with the FIFO non-empty pops one byte onto `par_data` and sets `out_valid` to 1.
- R6: When `mode_comb`=1 and a pace pulse finds the FIFO empty, `par_data` and `out_valid` keep their previous values. In both modes, outputs change only in cycles where `pace` is 1.
- R7: Bytes leave in the order they were accepted. Up to DEPTH bytes are held (6144 by default), and no byte is ever popped from an empty FIFO.
- R8: A write attempted while the FIFO holds DEPTH bytes is dropped, even if a byte is popped in the same cycle, and sets `ovf_flag`. The flag then stays 1 until it is cleared.
- R9: `ovf_clr`=1 clears `ovf_flag` in the next cycle, unless a dropped write happens in the same cycle, in which case the flag stays 1.
- R10: When `dl_sel`=1, only `host_wr`/`host_data` fill the FIFO and stream writes are ignored. When `dl_sel`=0, only `strm_wr`/`strm_data` fill it and host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_comb | input | 1 | 0: serial bit output, 1: combined byte-parallel output |
| rate_div | input | DIV_W | Serial pace period minus one, in clocks |
| byte_ratio | input | RATIO_W | Combined-mode pace period minus one, in clocks |
| dl_sel | input | 1 | 1 routes host writes into the FIFO instead of stream writes |
| strm_wr | input | 1 | Stream byte write strobe |
| strm_data | input | 8 | Stream byte |
| host_wr | input | 1 | Host byte write strobe |
| host_data | input | 8 | Host byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| ser_bit | output | 1 | Serial data bit |
| par_data | output | 8 | Byte-parallel data |
| out_valid | output | 1 | Output carries stream data |
| pace | output | 1 | One-cycle pulse when a new bit or byte slot begins |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The bench goes after the serial byte boundary. A design that popped a byte one pulse early would drop bit 0, and one that popped late would repeat a bit. Both appear as a `ser_bit` mismatch against a bench model that follows every pace pulse. It drains the FIFO in both modes: a design that forced valid low in combined mode, or held it high in serial mode, fails the per-cycle valid comparison. It fills the FIFO exactly to capacity, then writes again, and also pulses the clear in the same cycle as a dropped write, which catches an off-by-one full test and a clear that wins over a set. Download runs drive both write ports with different bytes, so a mux that listens to the wrong side shows up as wrong data.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;
    localparam logic [BIT_IDX_W-1:0] LAST_SHIFT = BIT_IDX_W'(BYTE_W - 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        OM_SERIAL   = 1'b0,
        OM_COMBINED = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic  en;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        byte_t                 sh;
        logic [BIT_IDX_W-1:0]  left;
        logic                  vld;
    } out_state_t;

    function automatic wr_req_t pick_src(input logic dl, input wr_req_t strm, input wr_req_t host);
        return dl ? host : strm;
    endfunction

endpackage

// File: rtl/aud_fifo_mem.sv
module aud_fifo_mem
    import aud_fifo_pkg::*;
#(
    parameter int DEPTH = 6144
) (
    input  logic                         clk,
    input  logic                         rst,
    input  wr_req_t                      wr,
    input  logic                         pop,
    input  logic                         ovf_clr,
    output byte_t                        rdata,
    output logic                         empty,
    output logic                         full,
    output logic                         ovf,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    byte_t             mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  cnt;
    logic              push, drop;

    assign empty = (cnt == '0);
    assign full  = (cnt == LVL_W'(DEPTH));
    assign push  = wr.en && !full;
    assign drop  = wr.en && full;
    assign rdata = mem[rd_ptr];
    assign level = cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/aud_rate_gen.sv
module aud_rate_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/aud_out_stage.sv
module aud_out_stage
    import aud_fifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  out_mode_e mode,
    input  logic      tick,
    input  logic      empty,
    input  byte_t     rdata,
    output logic      pop,
    output logic      ser_bit,
    output byte_t     par_data,
    output logic      valid,
    output logic      pace
);
    out_state_t st, nxt;

    always_comb begin
        nxt = st;
        pop = 1'b0;
        if (tick) begin
            if (mode == OM_SERIAL) begin
                if (st.vld && st.left != '0) begin
                    nxt.sh   = {st.sh[BYTE_W-2:0], 1'b0};
                    nxt.left = st.left - 1'b1;
                end else if (!empty) begin
                    pop      = 1'b1;
                    nxt.sh   = rdata;
                    nxt.left = LAST_SHIFT;
                    nxt.vld  = 1'b1;
                end else begin
                    nxt.left = '0;
                    nxt.vld  = 1'b0;
                end
            end else begin
                if (!empty) begin
                    pop      = 1'b1;
                    nxt.sh   = rdata;
                    nxt.left = '0;
                    nxt.vld  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            pace <= 1'b0;
        end else begin
            st   <= nxt;
            pace <= tick;
        end
    end

    assign ser_bit  = st.sh[BYTE_W-1];
    assign par_data = st.sh;
    assign valid    = st.vld;

endmodule

// File: rtl/aud_out_fifo.sv
module aud_out_fifo
    import aud_fifo_pkg::*;
#(
    parameter int DEPTH   = 6144,
    parameter int DIV_W   = 16,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_comb,
    input  logic [DIV_W-1:0]   rate_div,
    input  logic [RATIO_W-1:0] byte_ratio,
    input  logic               dl_sel,
    input  logic               strm_wr,
    input  logic [7:0]         strm_data,
    input  logic               host_wr,
    input  logic [7:0]         host_data,
    input  logic               ovf_clr,
    output logic               ser_bit,
    output logic [7:0]         par_data,
    output logic               out_valid,
    output logic               pace,
    output logic               ovf_flag
);
    localparam int LVL_W = $clog2(DEPTH+1);

    wr_req_t            strm_req, host_req, wr_sel;
    out_mode_e          mode;
    logic [DIV_W-1:0]   period;
    logic               tick, pop, empty, full;
    byte_t              rdata;
    logic [LVL_W-1:0]   level;

    assign strm_req = '{en: strm_wr, data: strm_data};
    assign host_req = '{en: host_wr, data: host_data};
    assign wr_sel   = pick_src(dl_sel, strm_req, host_req);
    assign mode     = out_mode_e'(mode_comb);
    assign period   = (mode == OM_COMBINED) ? DIV_W'(byte_ratio) : rate_div;

    aud_fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_sel),
        .pop     (pop),
        .ovf_clr (ovf_clr),
        .rdata   (rdata),
        .empty   (empty),
        .full    (full),
        .ovf     (ovf_flag),
        .level   (level)
    );

    aud_rate_gen #(.CNT_W(DIV_W)) u_rate (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .tick   (tick)
    );

    aud_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .tick     (tick),
        .empty    (empty),
        .rdata    (rdata),
        .pop      (pop),
        .ser_bit  (ser_bit),
        .par_data (par_data),
        .valid    (out_valid),
        .pace     (pace)
    );

endmodule

// File: rtl/aud_out_fifo_chk.sv
module aud_out_fifo_chk #(
    parameter int DEPTH = 6144,
    localparam int LVL_W = $clog2(DEPTH+1)
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             pace,
    input logic [7:0]       par_data,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic             wr_en,
    input logic             full,
    input logic             pop,
    input logic             empty,
    input logic [LVL_W-1:0] level
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_flag && empty));

    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !pace |-> $stable(par_data));

    p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !pace |-> $stable(out_valid));

    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> ovf_flag);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(wr_en && full)) |=> !ovf_flag);

endmodule

bind aud_out_fifo aud_out_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .pace      (pace),
    .par_data  (par_data),
    .ovf_flag  (ovf_flag),
    .ovf_clr   (ovf_clr),
    .wr_en     (wr_sel.en),
    .full      (full),
    .pop       (pop),
    .empty     (empty),
    .level     (level)
);

// File: tb/sim_aud_out_fifo.sv
`timescale 1ns/1ps
module sim_aud_out_fifo;
    localparam int DEPTH   = 16;
    localparam int DIV_W   = 16;
    localparam int RATIO_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               mode_comb = 1'b0;
    logic [DIV_W-1:0]   rate_div = '0;
    logic [RATIO_W-1:0] byte_ratio = '0;
    logic               dl_sel = 1'b0;
    logic               strm_wr = 1'b0, host_wr = 1'b0, ovf_clr = 1'b0;
    logic [7:0]         strm_data = '0, host_data = '0;
    logic               ser_bit, out_valid, pace, ovf_flag;
    logic [7:0]         par_data;

    aud_out_fifo #(.DEPTH(DEPTH), .DIV_W(DIV_W), .RATIO_W(RATIO_W)) u0 (
        .clk(clk), .rst(rst), .mode_comb(mode_comb), .rate_div(rate_div),
        .byte_ratio(byte_ratio), .dl_sel(dl_sel), .strm_wr(strm_wr),
        .strm_data(strm_data), .host_wr(host_wr), .host_data(host_data),
        .ovf_clr(ovf_clr), .ser_bit(ser_bit), .par_data(par_data),
        .out_valid(out_valid), .pace(pace), .ovf_flag(ovf_flag)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string ph     = "";

    logic [7:0] q[$];
    bit         m_vld;
    logic [7:0] m_sh;
    int         m_left;
    bit         m_ovf;
    int         gap;
    bit         seen;

    function automatic int cur_period();
        return mode_comb ? int'(byte_ratio) : int'(rate_div);
    endfunction

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] actual %0h expected %0h at %0t", tag, ph, got, exp, $time);
        end
    endtask

    task automatic do_reset(input bit comb, input int p);
        @(negedge clk);
        rst = 1'b1; strm_wr = 0; host_wr = 0; ovf_clr = 0; dl_sel = 0;
        mode_comb = comb;
        if (comb) byte_ratio = RATIO_W'(p); else rate_div = DIV_W'(p);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        chk(ovf_flag == 1'b0, "R1 ovf in reset", ovf_flag, 0);
        rst = 1'b0;
        q.delete(); m_vld = 0; m_sh = '0; m_left = 0; m_ovf = 0; gap = 0; seen = 0;
    endtask

    task automatic cyc(input bit dw, input logic [7:0] dd, input bit hw,
                       input logic [7:0] hd, input bit clr);
        int qb;
        bit wen;
        logic [7:0] wd;
        strm_wr = dw; strm_data = dd; host_wr = hw; host_data = hd; ovf_clr = clr;
        @(posedge clk);
        @(negedge clk);
        qb = q.size();
        gap++;
        if (pace) begin
            if (seen) chk(gap == cur_period() + 1, "R2 pace interval", gap, cur_period() + 1);
            seen = 1; gap = 0;
            if (!mode_comb) begin
                if (m_vld && m_left != 0) begin
                    m_sh = {m_sh[6:0], 1'b0}; m_left--;
                end else if (q.size() > 0) begin
                    m_sh = q.pop_front(); m_left = 7; m_vld = 1;
                end else begin
                    m_vld = 0; m_left = 0;
                end
                chk(out_valid == m_vld, "R4 serial valid", out_valid, m_vld);
                if (m_vld) chk(ser_bit == m_sh[7], "R3 serial bit", ser_bit, m_sh[7]);
            end else begin
                if (q.size() > 0) begin
                    m_sh = q.pop_front(); m_vld = 1;
                end
                chk(out_valid == m_vld, "R5 combined valid", out_valid, m_vld);
                chk(par_data == m_sh, "R5 R7 combined byte", par_data, m_sh);
            end
        end else begin
            chk(out_valid == m_vld, "R6 valid between pulses", out_valid, m_vld);
            if (mode_comb) chk(par_data == m_sh, "R6 byte between pulses", par_data, m_sh);
        end
        wen = dl_sel ? hw : dw;
        wd  = dl_sel ? hd : dd;
        if (wen) begin
            if (qb < DEPTH) q.push_back(wd);
            else m_ovf = 1;
        end
        if (clr && !(wen && qb >= DEPTH)) m_ovf = 0;
        chk(ovf_flag == m_ovf, "R8 R9 overflow flag", ovf_flag, m_ovf);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 8'h00, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_A11D));

        // serial, random sparse stream with host noise (R3, R4, R10 ignore side)
        ph = "R3";
        do_reset(0, 3);
        for (int i = 0; i < 900; i++)
            cyc($urandom_range(0, 39) == 0, 8'($urandom_range(0, 255)),
                $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)), 0);
        // burst then drain to underflow (R4)
        ph = "R4";
        for (int i = 0; i < 6; i++) cyc(1, 8'($urandom_range(0, 255)), 0, 8'h00, 0);
        idle(260);

        // serial at divider 0: one bit per clock
        ph = "R2";
        do_reset(0, 0);
        cyc(1, 8'hA5, 0, 8'h00, 0);
        cyc(1, 8'h3C, 0, 8'h00, 0);
        idle(40);

        // combined mode, random stream and underflow holds (R5, R6)
        ph = "R5";
        do_reset(1, 2);
        for (int i = 0; i < 700; i++)
            cyc($urandom_range(0, 4) == 0, 8'($urandom_range(0, 255)),
                $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)), 0);
        ph = "R6";
        idle(60);

        // overflow: slow drain, fill past capacity (R7, R8, R9)
        ph = "R8";
        do_reset(0, 1000);
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i * 7 + 1), 0, 8'h00, 0);
        chk(ovf_flag == 1'b0, "R7 exactly full no overflow", ovf_flag, 0);
        cyc(1, 8'hEE, 0, 8'h00, 0);
        chk(ovf_flag == 1'b1, "R8 overflow set", ovf_flag, 1);
        idle(3);
        chk(ovf_flag == 1'b1, "R8 overflow sticky", ovf_flag, 1);
        ph = "R9";
        cyc(0, 8'h00, 0, 8'h00, 1);
        chk(ovf_flag == 1'b0, "R9 overflow cleared", ovf_flag, 0);
        cyc(1, 8'hDD, 0, 8'h00, 1);
        chk(ovf_flag == 1'b1, "R9 set wins over clear", ovf_flag, 1);
        cyc(0, 8'h00, 0, 8'h00, 1);
        @(negedge clk);
        rate_div = DIV_W'(1);
        seen = 0;
        idle(300);

        // host download (R10)
        ph = "R10";
        do_reset(0, 2);
        dl_sel = 1'b1;
        for (int i = 0; i < 200; i++)
            cyc($urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)),
                $urandom_range(0, 9) == 0, 8'($urandom_range(0, 255)), 0);
        dl_sel = 1'b0;
        for (int i = 0; i < 200; i++)
            cyc($urandom_range(0, 19) == 0, 8'($urandom_range(0, 255)),
                $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)), 0);
        idle(400);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule